// File: doc/BRIEF.md
# UART Receive Character Buffer with Level Interrupt

This block holds the characters a UART has received until software takes them out through the data register. Each character is stored as a 12-bit word: eight data bits plus four error bits. Characters come from the line receiver or, when loopback is on, from the transmit loopback path. A line-break condition seen by the receiver is stored as a special word. Software reads one word per data-register access. Each read also loads the error bits of that word into a status register.

The buffer runs in one of two modes, chosen at run time by a FIFO-enable control bit. With the bit set it is a circular queue of `DEPTH` entries (16 by default). With the bit clear it is a single holding register. The full flag, the empty flag, the ready-to-accept signal and the receive-level interrupt all follow whichever depth is in use. Any change of the enable bit flushes the buffer.

Top module: `rxf_top`

## Requirements
- R1: The usable depth is `DEPTH` entries while `fifo_en` is 1 and one entry while it is 0. `rx_ready` is 1 exactly when the stored count is below the usable depth.
- R2: Words are returned in arrival order. The queue pointers wrap around the usable depth, so ordering survives any number of wrap-arounds.
- R3: `empty` is 1 while nothing is stored and `full` is 1 while the count equals the usable depth. They are never 1 together, and both are registered outputs.
- R4: `rd_data` always shows the word at the read position. A read with nothing stored returns that stale word, leaves the count and position unchanged, and keeps `empty` at 1.
- R5: A push that arrives while the buffer is full and no read is taken in the same cycle is dropped. The count, the pointers and the stored words stay unchanged.
- R6: The trigger level is 1. `irq_rx` is set when an accepted push brings the count to 1. It is cleared when a read leaves the count at 0. When both happen in the same cycle, the set wins.
- R7: In the cycle after `fifo_en` changes value, the count and read position are zero, `empty` is 1 and `full` is 0. A push or read in the cycle of the change is ignored, and `irq_rx` keeps its value.
- R8: With loopback off, a `brk_evt` pulse pushes the word 12'h400: data zero and break bit [10] set. The other error bits are framing [8], parity [9] and overrun [11]. `rx_err` bit i maps to word bit 8+i. A break outranks a line character arriving in the same cycle.
- R9: While `loop_en` is 1, only `lb_valid`/`lb_word` can push. `rx_valid` and `brk_evt` are ignored.
- R10: An accepted read loads `stat_err` with bits [11:8] of the word returned. `stat_clr` zeroes `stat_err`, and a read in the same cycle takes priority over the clear.
- R11: A read and a push in the same cycle act as a read followed by a push. A full buffer therefore accepts the push and stays full.
- R12: After reset the buffer is empty and not full, `rx_ready` is 1, and `irq_rx` and `stat_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | 1: queue of DEPTH entries, 0: single holding register |
| loop_en | input | 1 | Loopback mode: only the loopback path may push |
| rx_valid | input | 1 | Line receiver character strobe |
| rx_data | input | 8 | Line receiver character |
| rx_err | input | 4 | Line error bits {overrun, break, parity, framing} |
| brk_evt | input | 1 | Line-break event strobe |
| lb_valid | input | 1 | Loopback word strobe |
| lb_word | input | 12 | Loopback word |
| rd_en | input | 1 | Data-register read strobe |
| stat_clr | input | 1 | Clear the receive status bits |
| rd_data | output | 12 | Word at the read position |
| stat_err | output | 4 | Error bits of the last word read |
| full | output | 1 | Count equals the usable depth |
| empty | output | 1 | Nothing stored |
| rx_ready | output | 1 | Buffer can accept a character |
| irq_rx | output | 1 | Receive-level interrupt request (raw) |

## Verification
The bench builds the block with the default `DEPTH` of 16 and a trigger level of 1. In queue mode this lets a fill start from a read position other than zero, so pointer wrap, the full boundary and overflow drops are all exercised on the real depth. Clearing `fifo_en` at run time brings in the one-entry holding-register behaviour and the flush on each mode change without a second build.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int DATA_W = 8;
    localparam int ERR_W  = 4;
    localparam int WORD_W = DATA_W + ERR_W;

    // Stored receive word; the error nibble sits above the character.
    typedef struct packed {
        logic              overrun;   // [11]
        logic              brk;       // [10]
        logic              parity;    // [9]
        logic              framing;   // [8]
        logic [DATA_W-1:0] data;      // [7:0]
    } rxf_word_t;

    function automatic rxf_word_t rxf_break_word();
        rxf_word_t w;
        w     = '0;
        w.brk = 1'b1;
        return w;
    endfunction

    function automatic rxf_word_t rxf_char_word(logic [DATA_W-1:0] d,
                                                logic [ERR_W-1:0]  e);
        return rxf_word_t'({e, d});
    endfunction

    function automatic logic [ERR_W-1:0] rxf_err_of(rxf_word_t w);
        return {w.overrun, w.brk, w.parity, w.framing};
    endfunction

endpackage

// File: rtl/rxf_src.sv
module rxf_src
    import rxf_pkg::*;
(
    input  logic              loop_en,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic [ERR_W-1:0]  rx_err,
    input  logic              brk_evt,
    input  logic              lb_valid,
    input  logic [WORD_W-1:0] lb_word,
    output logic              push_v,
    output rxf_word_t         push_word
);

    always_comb begin
        if (loop_en) begin
            push_v    = lb_valid;
            push_word = rxf_word_t'(lb_word);
        end else if (brk_evt) begin
            push_v    = 1'b1;
            push_word = rxf_break_word();
        end else begin
            push_v    = rx_valid;
            push_word = rxf_char_word(rx_data, rx_err);
        end
    end

endmodule

// File: rtl/rxf_mem.sv
module rxf_mem
    import rxf_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int PW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [PW-1:0] wslot,
    input  rxf_word_t     wword,
    input  logic [PW-1:0] rslot,
    output rxf_word_t     rword
);

    rxf_word_t store [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)
                store[g] <= '0;
            else if (we && wslot == PW'(g))
                store[g] <= wword;
        end
    end

    assign rword = store[rslot];

endmodule

// File: rtl/rxf_ctl.sv
module rxf_ctl #(
    parameter  int DEPTH = 16,
    parameter  int TRIG  = 1,
    localparam int PW    = $clog2(DEPTH),
    localparam int CW    = PW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fifo_en,
    input  logic          push_v,
    input  logic          rd_en,
    output logic          wr_en,
    output logic [PW-1:0] wr_slot,
    output logic [PW-1:0] rd_slot,
    output logic [CW-1:0] cnt,
    output logic          full,
    output logic          empty,
    output logic          ready,
    output logic          rd_acc,
    output logic          irq_set,
    output logic          irq_clr
);

    logic          en_q, flush, take;
    logic [PW-1:0] pos, pos_a, mask;
    logic [CW-1:0] lim, cnt_a, cnt_n;

    always_comb begin
        mask    = fifo_en ? PW'(DEPTH - 1) : '0;
        lim     = fifo_en ? CW'(DEPTH) : CW'(1);
        flush   = fifo_en != en_q;
        rd_acc  = rd_en && !flush;
        take    = rd_acc && (cnt != '0);
        cnt_a   = cnt - CW'(take);
        pos_a   = (pos + PW'(take)) & mask;
        wr_en   = push_v && !flush && (cnt_a < lim);
        wr_slot = (pos_a + cnt_a[PW-1:0]) & mask;
        cnt_n   = cnt_a + CW'(wr_en);
        ready   = cnt < lim;
        irq_clr = rd_acc && ((cnt_a + CW'(1)) == CW'(TRIG));
        irq_set = wr_en && (cnt_n == CW'(TRIG));
        rd_slot = pos;
    end

    always_ff @(posedge clk) begin
        en_q <= fifo_en;
        if (rst || flush) begin
            cnt   <= '0;
            pos   <= '0;
            full  <= 1'b0;
            empty <= 1'b1;
        end else begin
            cnt <= cnt_n;
            pos <= pos_a;
            if (rd_acc)
                full <= 1'b0;
            if (wr_en && cnt_n == lim)
                full <= 1'b1;
            if (take && cnt_n == '0)
                empty <= 1'b1;
            if (wr_en)
                empty <= 1'b0;
        end
    end

endmodule

// File: rtl/rxf_irqst.sv
module rxf_irqst
    import rxf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             irq_set,
    input  logic             irq_clr,
    input  logic             rd_acc,
    input  logic [ERR_W-1:0] rd_err,
    input  logic             stat_clr,
    output logic             irq,
    output logic [ERR_W-1:0] stat
);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq  <= 1'b0;
            stat <= '0;
        end else begin
            if (irq_set)
                irq <= 1'b1;
            else if (irq_clr)
                irq <= 1'b0;
            if (rd_acc)
                stat <= rd_err;
            else if (stat_clr)
                stat <= '0;
        end
    end

endmodule

// File: rtl/rxf_top.sv
module rxf_top
    import rxf_pkg::*;
#(
    parameter  int DEPTH = 16,
    parameter  int TRIG  = 1,
    localparam int PW    = $clog2(DEPTH),
    localparam int CW    = PW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_en,
    input  logic              loop_en,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic [ERR_W-1:0]  rx_err,
    input  logic              brk_evt,
    input  logic              lb_valid,
    input  logic [WORD_W-1:0] lb_word,
    input  logic              rd_en,
    input  logic              stat_clr,
    output logic [WORD_W-1:0] rd_data,
    output logic [ERR_W-1:0]  stat_err,
    output logic              full,
    output logic              empty,
    output logic              rx_ready,
    output logic              irq_rx
);

    logic          push_v, wr_en, rd_acc, irq_set, irq_clr;
    logic [PW-1:0] wr_slot, rd_slot;
    logic [CW-1:0] cnt_w;
    rxf_word_t     push_word, head;

    rxf_src u_src (
        .loop_en  (loop_en),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .rx_err   (rx_err),
        .brk_evt  (brk_evt),
        .lb_valid (lb_valid),
        .lb_word  (lb_word),
        .push_v   (push_v),
        .push_word(push_word)
    );

    rxf_ctl #(.DEPTH(DEPTH), .TRIG(TRIG)) u_ctl (
        .clk    (clk),
        .rst    (rst),
        .fifo_en(fifo_en),
        .push_v (push_v),
        .rd_en  (rd_en),
        .wr_en  (wr_en),
        .wr_slot(wr_slot),
        .rd_slot(rd_slot),
        .cnt    (cnt_w),
        .full   (full),
        .empty  (empty),
        .ready  (rx_ready),
        .rd_acc (rd_acc),
        .irq_set(irq_set),
        .irq_clr(irq_clr)
    );

    rxf_mem #(.DEPTH(DEPTH)) u_mem (
        .clk  (clk),
        .rst  (rst),
        .we   (wr_en),
        .wslot(wr_slot),
        .wword(push_word),
        .rslot(rd_slot),
        .rword(head)
    );

    rxf_irqst u_irq (
        .clk     (clk),
        .rst     (rst),
        .irq_set (irq_set),
        .irq_clr (irq_clr),
        .rd_acc  (rd_acc),
        .rd_err  (rxf_err_of(head)),
        .stat_clr(stat_clr),
        .irq     (irq_rx),
        .stat    (stat_err)
    );

    assign rd_data = WORD_W'(head);

endmodule

// File: rtl/rxf_chk.sv
module rxf_chk #(
    parameter int CW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          fifo_en,
    input logic          loop_en,
    input logic          rx_valid,
    input logic          brk_evt,
    input logic          lb_valid,
    input logic          rd_en,
    input logic          full,
    input logic          empty,
    input logic          rx_ready,
    input logic          irq_rx,
    input logic [11:0]   rd_data,
    input logic [CW-1:0] cnt
);

    logic en_d, flush_c, push_any;

    always_ff @(posedge clk) en_d <= fifo_en;

    assign flush_c  = fifo_en != en_d;
    assign push_any = loop_en ? lb_valid : (brk_evt || rx_valid);

    assert_flags_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));

    assert_ready_full_R1: assert property (@(posedge clk) disable iff (rst)
        !flush_c |-> (rx_ready == !full));

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        (full && !rd_en && !flush_c) |=> (full && $stable(cnt)));

    assert_irq_first_R6: assert property (@(posedge clk) disable iff (rst)
        (empty && push_any && !rd_en && !flush_c) |=> irq_rx);

    assert_flush_R7: assert property (@(posedge clk) disable iff (rst)
        flush_c |=> (empty && !full));

    assert_break_word_R8: assert property (@(posedge clk) disable iff (rst)
        (empty && brk_evt && !loop_en && !rd_en && !flush_c) |=> (rd_data == 12'h400));

    assert_loop_gate_R9: assert property (@(posedge clk) disable iff (rst)
        (loop_en && !lb_valid && !rd_en && !flush_c) |=> $stable(cnt));

endmodule

bind rxf_top rxf_chk #(.CW(CW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .fifo_en (fifo_en),
    .loop_en (loop_en),
    .rx_valid(rx_valid),
    .brk_evt (brk_evt),
    .lb_valid(lb_valid),
    .rd_en   (rd_en),
    .full    (full),
    .empty   (empty),
    .rx_ready(rx_ready),
    .irq_rx  (irq_rx),
    .rd_data (rd_data),
    .cnt     (cnt_w)
);

// File: tb/sim_rxf_top.sv
module sim_rxf_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fifo_en = 1'b1, loop_en = 1'b0;
    logic        rx_valid = 1'b0, brk_evt = 1'b0, lb_valid = 1'b0;
    logic        rd_en = 1'b0, stat_clr = 1'b0;
    logic [7:0]  rx_data = '0;
    logic [3:0]  rx_err = '0;
    logic [11:0] lb_word = '0;
    logic [11:0] rd_data;
    logic [3:0]  stat_err;
    logic        full, empty, rx_ready, irq_rx;

    int total = 0;
    int bad   = 0;
    logic [11:0] cap;

    always #2 clk = ~clk;

    rxf_top u0 (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .loop_en(loop_en),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_err(rx_err),
        .brk_evt(brk_evt), .lb_valid(lb_valid), .lb_word(lb_word),
        .rd_en(rd_en), .stat_clr(stat_clr), .rd_data(rd_data),
        .stat_err(stat_err), .full(full), .empty(empty),
        .rx_ready(rx_ready), .irq_rx(irq_rx)
    );

    // op[0] = line push, op[1] = read; then word, expected read word, full, empty, irq, ready
    localparam logic [29:0] VEC [7] = '{
        {2'd1, 12'h041, 12'h000, 1'b0, 1'b0, 1'b1, 1'b1},
        {2'd1, 12'h142, 12'h000, 1'b0, 1'b0, 1'b1, 1'b1},
        {2'd2, 12'h000, 12'h041, 1'b0, 1'b0, 1'b1, 1'b1},
        {2'd2, 12'h000, 12'h142, 1'b0, 1'b1, 1'b0, 1'b1},
        {2'd2, 12'h000, 12'h000, 1'b0, 1'b1, 1'b0, 1'b1},
        {2'd3, 12'h2AA, 12'h000, 1'b0, 1'b0, 1'b1, 1'b1},
        {2'd2, 12'h000, 12'h2AA, 1'b0, 1'b1, 1'b0, 1'b1}
    };

    task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle of stimulus, entered and left at a falling edge.
    task automatic cyc(input logic lv, input logic lb, input logic bk,
                       input logic rd, input logic cl, input logic [11:0] w);
        rx_valid = lv; rx_data = w[7:0]; rx_err = w[11:8];
        lb_valid = lb; lb_word = w;
        brk_evt = bk; rd_en = rd; stat_clr = cl;
        #1 cap = rd_data;
        @(posedge clk);
        #1;
        rx_valid = 0; lb_valid = 0; brk_evt = 0; rd_en = 0; stat_clr = 0;
        @(negedge clk);
    endtask

    task automatic flags(input string tag, input logic f, input logic e,
                         input logic i, input logic r);
        chk({tag, " full"},  {11'd0, full},     {11'd0, f});
        chk({tag, " empty"}, {11'd0, empty},    {11'd0, e});
        chk({tag, " irq"},   {11'd0, irq_rx},   {11'd0, i});
        chk({tag, " ready"}, {11'd0, rx_ready}, {11'd0, r});
    endtask

    initial begin
        #(200000 * 4);
        bad++; total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);

        // R12 reset state
        flags("R12 reset", 1'b0, 1'b1, 1'b0, 1'b1);
        chk("R12 stat", {8'd0, stat_err}, 12'h000);

        // Table walk: R2 order, R4 empty read, R6 irq, R11 read+push
        for (int k = 0; k < 7; k++) begin
            logic [29:0] v;
            v = VEC[k];
            cyc(v[28], 1'b0, 1'b0, v[29], 1'b0, v[27:16]);
            if (v[29]) chk($sformatf("R2/R4/R11 vec%0d rd", k), cap, v[15:4]);
            flags($sformatf("R3/R6 vec%0d", k), v[3], v[2], v[1], v[0]);
        end

        // Fill from a non-zero read position (wraps), overflow, drain: R1 R2 R3 R5
        for (int i = 0; i < 16; i++) cyc(1, 0, 0, 0, 0, 12'h010 + 12'(i));
        flags("R1 full16", 1'b1, 1'b0, 1'b1, 1'b0);
        cyc(1, 0, 0, 0, 0, 12'hFFF);
        flags("R5 drop", 1'b1, 1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 16; i++) begin
            cyc(0, 0, 0, 1, 0, 12'h000);
            chk("R2 drain order", cap, 12'h010 + 12'(i));
        end
        flags("R3 drained", 1'b0, 1'b1, 1'b0, 1'b1);

        // R11 read+push while full
        for (int i = 0; i < 16; i++) cyc(1, 0, 0, 0, 0, 12'h020 + 12'(i));
        cyc(1, 0, 0, 1, 0, 12'h0AB);
        chk("R11 head", cap, 12'h020);
        flags("R11 stays full", 1'b1, 1'b0, 1'b1, 1'b0);

        // R7 flush on switching to one-entry mode; irq kept
        fifo_en = 1'b0;
        @(posedge clk); @(negedge clk);
        flags("R7 flush", 1'b0, 1'b1, 1'b1, 1'b1);

        // One-entry mode: R1 R4 R5 R6
        cyc(0, 0, 0, 1, 0, 12'h000);
        flags("R6 clr on empty read", 1'b0, 1'b1, 1'b0, 1'b1);
        cyc(1, 0, 0, 0, 0, 12'h055);
        flags("R1 depth1 full", 1'b1, 1'b0, 1'b1, 1'b0);
        cyc(1, 0, 0, 0, 0, 12'h066);
        flags("R5 depth1 drop", 1'b1, 1'b0, 1'b1, 1'b0);
        cyc(0, 0, 0, 1, 0, 12'h000);
        chk("R5 depth1 kept word", cap, 12'h055);
        flags("R4 depth1 emptied", 1'b0, 1'b1, 1'b0, 1'b1);

        // R8 break word, break beats a line char in the same cycle; R10 status
        cyc(1, 0, 1, 0, 0, 12'h0EE);
        cyc(0, 0, 0, 1, 0, 12'h000);
        chk("R8 break word", cap, 12'h400);
        chk("R10 stat break", {8'd0, stat_err}, 12'h004);
        cyc(0, 0, 0, 0, 1, 12'h000);
        chk("R10 stat clr", {8'd0, stat_err}, 12'h000);
        cyc(1, 0, 0, 0, 0, 12'h977);
        cyc(0, 0, 0, 1, 1, 12'h000);
        chk("R10 char word", cap, 12'h977);
        chk("R10 read beats clr", {8'd0, stat_err}, 12'h009);

        // R9 loopback gating
        loop_en = 1'b1;
        cyc(1, 0, 0, 0, 0, 12'h011);
        flags("R9 line ignored", 1'b0, 1'b1, 1'b0, 1'b1);
        cyc(0, 0, 1, 0, 0, 12'h000);
        flags("R9 break ignored", 1'b0, 1'b1, 1'b0, 1'b1);
        cyc(0, 1, 0, 0, 0, 12'h833);
        flags("R9 loop push", 1'b1, 1'b0, 1'b1, 1'b0);
        cyc(0, 0, 0, 1, 0, 12'h000);
        chk("R9 loop word", cap, 12'h833);
        loop_en = 1'b0;

        // R7 flush back to queue mode, push in the change cycle ignored
        cyc(1, 0, 0, 0, 0, 12'h0CC);
        fifo_en = 1'b1;
        cyc(1, 0, 0, 0, 0, 12'h0DD);
        flags("R7 flush drops push", 1'b0, 1'b1, 1'b1, 1'b1);
        cyc(1, 0, 0, 0, 0, 12'h0EE);
        cyc(0, 0, 0, 1, 0, 12'h000);
        chk("R7 pos reset", cap, 12'h0EE);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule